// File: doc/BRIEF.md
# TDC Readout Event Merger

This block gathers time-to-digital hit words from a set of per-channel event queues and turns them into one ordered readout stream for a single connector. Each channel queue presents 27-bit entries through a valid/ready pair. An entry is either a measured edge or an end-of-event marker. The merger serves the channels that still owe data for the current event in round-robin order. It formats each measured edge as a 32-bit readout word. The word carries a 5-bit format code, the connector number, the channel number, the edge polarity, the coarse count and the split fine time.

Words are framed in blocks. A block opens with a header that carries a running block number. Each event in the block starts with an event header that carries the trigger number taken from a trigger valid/ready input. The event's hits follow the header. After a fixed number of events, a trailer closes the block with the block's word count. An event header goes out only when a trigger is pending and every channel queue has an entry ready. Every channel must deliver its end marker before the next event begins. The output is a registered valid/ready stream that feeds a bus readout buffer. Wider merge trees are built by cascading instances of this block.

Top module: `tdc_event_merger`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `o_valid`, `trig_ready` and every `ch_ready` bit are low.
- R2: A hit word has `o_data[31:27]` = HIT code (default 5'h00), [26:24] = `conn_id`, [23:19] = CH_BASE plus the channel's input index, and [18:0] copied from the input entry: bit 18 is the edge (1 rising, 0 falling), 17:8 the coarse count in 4 ns units, bit 7 the 2 ns half, 6:0 the fine time. Input bits 25:19 of a hit are ignored.
- R3: An input entry with bit 26 set is an end-of-event marker. It is consumed and produces no output word.
- R4: The stream order is: block header (code 5'h18), then for each event an event header (code 5'h19) followed by that event's hits, then after EVT_PER_BLK events a block trailer (code 5'h1A). Bits 26:24 of every framing word hold `conn_id`.
- R5: An event header is emitted, and the trigger consumed, only when `trig_valid` is high and every `ch_valid` bit is high. Its bits 23:0 carry `trig_num`.
- R6: Channels are served round-robin. After channel i is granted, the next grant goes to the first channel after i, wrapping cyclically, that is valid and has not yet delivered its end marker. The pointer starts at channel 0 after reset and carries over across events.
- R7: No entry of a channel is consumed after that channel's end marker until the next event header has been emitted.
- R8: While `o_valid` is high and `o_ready` is low, `o_valid` stays high and `o_data` holds. No word is lost or duplicated.
- R9: The block header's bits 23:0 carry the block number, starting at 0 and incrementing by one per block. The trailer's bits 23:0 carry the number of words in the block, counting the header and the trailer themselves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conn_id | input | 3 | Connector number written into every word |
| ch_valid | input | N_CH | Per-channel entry available |
| ch_data | input | N_CH*27 | Per-channel entries, channel i at bits [27*i +: 27] |
| ch_ready | output | N_CH | Per-channel entry consumed |
| trig_valid | input | 1 | Trigger number available |
| trig_num | input | 24 | Trigger (event) number |
| trig_ready | output | 1 | Trigger number consumed |
| o_valid | output | 1 | Readout word valid |
| o_data | output | 32 | Readout word |
| o_ready | input | 1 | Downstream accepts the word |

## Verification
Three blocks of two events are pushed through, with every channel preloaded and between zero and three hits per channel per event. Some channels are empty in some events, which separates true round-robin order from fixed-priority or per-event-reset pointers. The first block runs with the sink always ready. The second runs with the sink stalling one cycle in three, and the third with long stall bursts. Comparing these shows whether words are dropped, duplicated or altered under backpressure. In the third block, one channel's data is withheld after the block header. This shows whether the event header waits for every channel or leaks out early. Hit entries carry junk in their unused bits, and hits sit queued behind markers, so field masking and the end-of-event gate are both exposed.

// File: rtl/tdc_merge_pkg.sv
package tdc_merge_pkg;

   localparam int unsigned IN_W     = 27;
   localparam int unsigned OUT_W    = 32;
   localparam int unsigned FMT_W    = 5;
   localparam int unsigned PAY_W    = 24;
   localparam int unsigned HIT_W    = 19;
   localparam int unsigned CHN_W    = 5;
   localparam int unsigned MARK_BIT = 26;

   typedef enum logic [1:0] {
      ST_BHDR,
      ST_EHDR,
      ST_DATA,
      ST_TRL
   } mrg_state_t;

   typedef enum logic [1:0] {
      WK_BHDR,
      WK_EHDR,
      WK_HIT,
      WK_TRL
   } word_kind_t;

endpackage

// File: rtl/tdc_rr_arbiter.sv
module tdc_rr_arbiter #(
   parameter int unsigned N    = 8,
   parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req,
   input  logic            adv,
   output logic [N-1:0]    gnt,
   output logic [IDXW-1:0] idx,
   output logic            any
);

   if (N < 1) begin : g_bad_n
      $error("tdc_rr_arbiter: N must be at least 1");
   end

   if (N == 1) begin : g_single
      assign gnt = req;
      assign idx = '0;
      assign any = req[0];
   end else begin : g_rr
      logic [IDXW-1:0] ptr;

      always_comb begin
         gnt = '0;
         idx = '0;
         any = 1'b0;
         for (int k = 0; k < int'(N); k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= int'(N)) j = j - int'(N);
            if (!any && req[j]) begin
               any    = 1'b1;
               gnt[j] = 1'b1;
               idx    = IDXW'(j);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ptr <= '0;
         end else if (adv && any) begin
            ptr <= (idx == IDXW'(N - 1)) ? '0 : idx + 1'b1;
         end
      end

      // R6: a grant is a single requesting channel
      a_r6_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(gnt) && ((gnt & ~req) == '0));

      // R6: after a grant the pointer moves just past the granted channel
      a_r6_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && any) |=> (ptr == (($past(idx) == IDXW'(N - 1)) ? '0 : $past(idx) + 1'b1)));
   end

endmodule

// File: rtl/tdc_word_fmt.sv
module tdc_word_fmt
   import tdc_merge_pkg::*;
#(
   parameter logic [FMT_W-1:0] FMT_BHDR = 5'h18,
   parameter logic [FMT_W-1:0] FMT_EHDR = 5'h19,
   parameter logic [FMT_W-1:0] FMT_HIT  = 5'h00,
   parameter logic [FMT_W-1:0] FMT_TRL  = 5'h1A
) (
   input  word_kind_t        kind,
   input  logic [2:0]        conn,
   input  logic [CHN_W-1:0]  chan,
   input  logic [HIT_W-1:0]  hit,
   input  logic [PAY_W-1:0]  payload,
   output logic [OUT_W-1:0]  word
);

   always_comb begin
      unique case (kind)
         WK_BHDR: word = {FMT_BHDR, conn, payload};
         WK_EHDR: word = {FMT_EHDR, conn, payload};
         WK_HIT:  word = {FMT_HIT,  conn, chan, hit};
         default: word = {FMT_TRL,  conn, payload};
      endcase
   end

endmodule

// File: rtl/tdc_event_merger.sv
module tdc_event_merger
   import tdc_merge_pkg::*;
#(
   parameter int unsigned      N_CH        = 8,
   parameter int unsigned      CH_BASE     = 0,
   parameter int unsigned      EVT_PER_BLK = 2,
   parameter logic [FMT_W-1:0] FMT_BHDR    = 5'h18,
   parameter logic [FMT_W-1:0] FMT_EHDR    = 5'h19,
   parameter logic [FMT_W-1:0] FMT_HIT     = 5'h00,
   parameter logic [FMT_W-1:0] FMT_TRL     = 5'h1A
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           conn_id,
   input  logic [N_CH-1:0]      ch_valid,
   input  logic [N_CH*IN_W-1:0] ch_data,
   output logic [N_CH-1:0]      ch_ready,
   input  logic                 trig_valid,
   input  logic [PAY_W-1:0]     trig_num,
   output logic                 trig_ready,
   output logic                 o_valid,
   output logic [OUT_W-1:0]     o_data,
   input  logic                 o_ready
);

   localparam int unsigned IDXW = (N_CH > 1) ? $clog2(N_CH) : 1;
   localparam int unsigned EVW  = $clog2(EVT_PER_BLK + 1);

   if (N_CH < 1 || CH_BASE + N_CH > 32) begin : g_bad_ch
      $error("tdc_event_merger: channel numbers must fit in 0..31");
   end
   if (EVT_PER_BLK < 1) begin : g_bad_epb
      $error("tdc_event_merger: EVT_PER_BLK must be at least 1");
   end
   if (FMT_BHDR == FMT_EHDR || FMT_BHDR == FMT_HIT || FMT_BHDR == FMT_TRL ||
       FMT_EHDR == FMT_HIT  || FMT_EHDR == FMT_TRL || FMT_HIT  == FMT_TRL) begin : g_bad_fmt
      $error("tdc_event_merger: format codes must be distinct");
   end

   // per-channel unpack
   logic [IN_W-1:0]  chd   [N_CH];
   logic [CHN_W-1:0] chnum [N_CH];
   logic [N_CH-1:0]  ch_mark;

   for (genvar g = 0; g < int'(N_CH); g++) begin : g_ch
      assign chd[g]     = ch_data[g*IN_W +: IN_W];
      assign chnum[g]   = CHN_W'(CH_BASE + g);
      assign ch_mark[g] = ch_data[g*IN_W + MARK_BIT];
   end

   mrg_state_t       state;
   logic [N_CH-1:0]  done, done_nxt;
   logic [EVW-1:0]   evt_cnt;
   logic [PAY_W-1:0] blk_cnt;
   logic [PAY_W-1:0] wcnt;

   logic             can_load;
   logic             emit;
   logic             adv;
   word_kind_t       kind;
   logic [PAY_W-1:0] payload;
   logic [OUT_W-1:0] word;

   logic [N_CH-1:0]  arb_gnt;
   logic [IDXW-1:0]  arb_idx;
   logic             arb_any;
   logic             sel_mark;

   tdc_rr_arbiter #(.N(N_CH), .IDXW(IDXW)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ch_valid & ~done),
      .adv   (adv),
      .gnt   (arb_gnt),
      .idx   (arb_idx),
      .any   (arb_any)
   );

   assign sel_mark = ch_mark[arb_idx];
   assign can_load = !o_valid || o_ready;

   tdc_word_fmt #(
      .FMT_BHDR (FMT_BHDR),
      .FMT_EHDR (FMT_EHDR),
      .FMT_HIT  (FMT_HIT),
      .FMT_TRL  (FMT_TRL)
   ) u_fmt (
      .kind    (kind),
      .conn    (conn_id),
      .chan    (chnum[arb_idx]),
      .hit     (chd[arb_idx][HIT_W-1:0]),
      .payload (payload),
      .word    (word)
   );

   always_comb begin
      emit       = 1'b0;
      adv        = 1'b0;
      kind       = WK_HIT;
      payload    = '0;
      trig_ready = 1'b0;
      unique case (state)
         ST_BHDR: begin
            kind    = WK_BHDR;
            payload = blk_cnt;
            emit    = trig_valid && can_load;
         end
         ST_EHDR: begin
            kind       = WK_EHDR;
            payload    = trig_num;
            emit       = trig_valid && (&ch_valid) && can_load;
            trig_ready = emit;
         end
         ST_DATA: begin
            adv  = can_load && arb_any;
            emit = adv && !sel_mark;
         end
         default: begin
            kind    = WK_TRL;
            payload = wcnt + 1'b1;
            emit    = can_load;
         end
      endcase
      done_nxt = done | ((adv && sel_mark) ? arb_gnt : '0);
   end

   assign ch_ready = adv ? arb_gnt : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_BHDR;
         done    <= '0;
         evt_cnt <= '0;
         blk_cnt <= '0;
         wcnt    <= '0;
         o_valid <= 1'b0;
         o_data  <= '0;
      end else begin
         if (emit) begin
            o_valid <= 1'b1;
            o_data  <= word;
         end else if (o_ready) begin
            o_valid <= 1'b0;
         end
         unique case (state)
            ST_BHDR: if (emit) begin
               state <= ST_EHDR;
               wcnt  <= PAY_W'(1);
            end
            ST_EHDR: if (emit) begin
               state <= ST_DATA;
               done  <= '0;
               wcnt  <= wcnt + 1'b1;
            end
            ST_DATA: if (adv) begin
               done <= done_nxt;
               if (emit) wcnt <= wcnt + 1'b1;
               if (&done_nxt) begin
                  if (evt_cnt == EVW'(EVT_PER_BLK - 1)) begin
                     evt_cnt <= '0;
                     state   <= ST_TRL;
                  end else begin
                     evt_cnt <= evt_cnt + 1'b1;
                     state   <= ST_EHDR;
                  end
               end
            end
            default: if (emit) begin
               blk_cnt <= blk_cnt + 1'b1;
               state   <= ST_BHDR;
            end
         endcase
      end
   end

   // R8: a stalled word is held unchanged
   a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));

   // R3: entries are only consumed from channels that offer one
   a_r3_pop_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ready & ~ch_valid) == '0);

   // R7: a channel that gave its marker is left alone for the rest of the event
   a_r7_no_pop_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ready & done) == '0);

   // R5: triggers are taken only with every channel ready
   a_r5_trig_gate: assert property (@(posedge clk) disable iff (!rst_n)
      trig_ready |-> (trig_valid && (&ch_valid)));

   // R4: every output word carries one of the four format codes
   a_r4_fmt_known: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (o_data[31:27] == FMT_BHDR || o_data[31:27] == FMT_EHDR ||
                   o_data[31:27] == FMT_HIT  || o_data[31:27] == FMT_TRL));

   // R1: nothing is consumed or offered in the first cycle after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!o_valid && ch_ready == '0 && !trig_ready));

endmodule

// File: tb/tb_tdc_event_merger.sv
module tb_tdc_event_merger;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int CHB        = 8;
   localparam int EPB        = 2;
   localparam int NEVT       = 6;
   localparam int HOLD_CH    = 3;
   localparam logic [2:0] CONN = 3'd5;
   localparam logic [4:0] F_BH = 5'h18, F_EH = 5'h19, F_HIT = 5'h00, F_TR = 5'h1A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  ch_valid = '0;
   logic [N*27-1:0] ch_data = '0;
   logic [N-1:0]  ch_ready;
   logic          trig_valid = 1'b0;
   logic [23:0]   trig_num = '0;
   logic          trig_ready;
   logic          o_valid;
   logic [31:0]   o_data;
   logic          o_ready = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tdc_event_merger #(.N_CH(N), .CH_BASE(CHB), .EVT_PER_BLK(EPB)) dut (
      .clk(clk), .rst_n(rst_n), .conn_id(CONN),
      .ch_valid(ch_valid), .ch_data(ch_data), .ch_ready(ch_ready),
      .trig_valid(trig_valid), .trig_num(trig_num), .trig_ready(trig_ready),
      .o_valid(o_valid), .o_data(o_data), .o_ready(o_ready)
   );

   int n_chk = 0, n_err = 0, n_out = 0, n_total = 0, cyc = 0;
   int mode = 0;
   bit running = 0, r5_win = 0, finished = 0;
   int sz_b0 = 0, sz_b1 = 0;

   logic [26:0] chq  [N][$];
   logic [26:0] hold [$];
   logic [23:0] trq  [$];
   logic [31:0] expq [$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [31:0] w);
      case (w[31:27])
         F_BH:    return "R4 R9 block header";
         F_EH:    return "R4 R5 event header";
         F_TR:    return "R4 R9 trailer";
         default: return "R2 R3 R6 R7 hit";
      endcase
   endfunction

   // model state
   int m_ptr = 0, m_blk = 0, m_evt = 0, m_wc = 0;

   task automatic build_event(input int e);
      logic [26:0] items [N][$];
      bit [N-1:0] dn;
      logic [23:0] tn;
      int nh;
      tn = 24'h100 + 24'(e * 7);
      trq.push_back(tn);
      for (int c = 0; c < N; c++) begin
         nh = (e * 3 + c * 5) % 4;
         for (int k = 0; k < nh; k++) begin
            logic [18:0] hb;
            hb = {1'(k + c), 10'((e * 37 + c * 11 + k * 5) % 1024), 1'(e + k), 7'((c * 19 + k * 23 + e) % 128)};
            items[c].push_back({1'b0, 7'(e * 13 + c + 1), hb});
         end
         items[c].push_back({1'b1, 26'h0});
         for (int k = 0; k < items[c].size(); k++) begin
            if (c == HOLD_CH && e >= 4) hold.push_back(items[c][k]);
            else chq[c].push_back(items[c][k]);
         end
      end
      if (m_evt == 0) begin
         expq.push_back({F_BH, CONN, 24'(m_blk)});
         m_wc = 1;
      end
      expq.push_back({F_EH, CONN, tn});
      m_wc++;
      dn = '0;
      while (dn != '1) begin
         int i;
         i = -1;
         for (int k = 0; k < N; k++) begin
            int j;
            j = (m_ptr + k) % N;
            if (i < 0 && !dn[j]) i = j;
         end
         if (items[i][0][26]) dn[i] = 1'b1;
         else begin
            expq.push_back({F_HIT, CONN, 5'(CHB + i), items[i][0][18:0]});
            m_wc++;
         end
         void'(items[i].pop_front());
         m_ptr = (i + 1) % N;
      end
      m_evt++;
      if (m_evt == EPB) begin
         expq.push_back({F_TR, CONN, 24'(m_wc + 1)});
         m_evt = 0;
         m_blk++;
      end
   endtask

   // driver + monitor
   initial begin
      bit [N-1:0] pend_ch;
      bit pend_tr, stall, fire;
      logic [31:0] held, ew;
      pend_ch = '0; pend_tr = 0; stall = 0; held = '0;
      wait (running);
      forever begin
         @(negedge clk);
         for (int i = 0; i < N; i++) if (pend_ch[i]) void'(chq[i].pop_front());
         if (pend_tr) void'(trq.pop_front());
         if (stall) chk(o_valid && o_data == held, "R8 stalled word held", o_data, held);
         case (mode)
            1:       o_ready = (cyc % 3) != 0;
            2:       o_ready = (cyc % 8) >= 5;
            default: o_ready = 1'b1;
         endcase
         for (int i = 0; i < N; i++) begin
            ch_valid[i] = chq[i].size() > 0;
            ch_data[i*27 +: 27] = (chq[i].size() > 0) ? chq[i][0] : 27'h0;
         end
         trig_valid = trq.size() > 0;
         trig_num   = (trq.size() > 0) ? trq[0] : 24'h0;
         #1;
         pend_ch = ch_valid & ch_ready;
         pend_tr = trig_valid && trig_ready;
         fire = o_valid && o_ready;
         if (fire) begin
            if (expq.size() == 0) chk(1'b0, "R8 extra word", o_data, 32'h0);
            else begin
               ew = expq.pop_front();
               chk(o_data == ew, tag_of(ew), o_data, ew);
            end
            n_out++;
         end
         if (r5_win) chk(!fire && !trig_ready, "R5 header waits for all channels",
                         {30'h0, fire, trig_ready}, 32'h0);
         stall = o_valid && !o_ready;
         held  = o_data;
         cyc++;
         if (cyc > 100000 && !finished) begin
            chk(1'b0, "watchdog", 32'(n_out), 32'(n_total));
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
         end
      end
   end

   // control
   initial begin
      int base;
      repeat (3) @(posedge clk);
      for (int e = 0; e < NEVT; e++) begin
         build_event(e);
         if (e == 1) sz_b0 = expq.size();
         if (e == 3) sz_b1 = expq.size() - sz_b0;
      end
      n_total = expq.size();
      // present inputs during reset
      @(negedge clk);
      ch_valid = '1;
      trig_valid = 1'b1;
      #1;
      chk(!o_valid && ch_ready == '0 && !trig_ready, "R1 quiet in reset",
          {30'h0, o_valid, trig_ready}, 32'h0);
      ch_valid = '0;
      trig_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!o_valid && ch_ready == '0 && !trig_ready, "R1 quiet after reset",
          {30'h0, o_valid, trig_ready}, 32'h0);
      mode = 0;
      running = 1;
      wait (n_out >= sz_b0);
      mode = 1;
      wait (n_out >= sz_b0 + sz_b1);
      mode = 0;
      base = sz_b0 + sz_b1 + 1;
      wait (n_out >= base);
      @(negedge clk);
      #2;
      r5_win = 1;
      repeat (20) @(negedge clk);
      #2;
      r5_win = 0;
      while (hold.size() > 0) chq[HOLD_CH].push_back(hold.pop_front());
      mode = 2;
      wait (n_out >= n_total);
      repeat (10) @(negedge clk);
      #2;
      finished = 1;
      chk(n_out == n_total, "R8 word count", 32'(n_out), 32'(n_total));
      chk(o_valid == 1'b0, "R8 no extra word", {31'h0, o_valid}, 32'h0);
      for (int i = 0; i < N; i++)
         chk(chq[i].size() == 0, "R7 all channel entries consumed", 32'(chq[i].size()), 32'h0);
      chk(trq.size() == 0, "R5 all triggers consumed", 32'(trq.size()), 32'h0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule